// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block keeps a table of interrupt vectors for a device function. Each vector holds a 64-bit message address, a 32-bit message data word and a per-vector mask bit. Device logic raises requests by vector index. When the vector is usable and not masked, the block sends a message write, which carries the entry's data to the entry's address, on a valid/ready channel. When the vector is masked, the request is stored in a pending-bit array. Software reads and writes the table through a 32-bit register port. It can read the pending array through a second, read-only port.

The function-level enable and mask-all bits come from the capability register that owns them. The function counts as masked when enable is low or mask-all is high, and that mask sits above every per-vector mask. A sequencer examines one vector per cycle and raises a busy flag while it runs. It starts when a per-vector mask is cleared by a table write, when the function mask drops, or when a request had to be parked because the output channel was stalled. During a pass it sends every pending vector that is now unmasked and clears that vector's pending bit.

Top module: `msgvec_ctrl`

## Requirements
- R1: After reset every vector reads address 0, data 0 and mask bit 1. The pending array reads all zero, `msg_valid` and `scan_busy` are low, and the same holds after a reset applied in mid-operation.
- R2: Vector v occupies table byte offsets 16v to 16v+15. Offset +0 holds address bits 31:0, +4 holds address bits 63:32, +8 holds the data word, and +12 is the control word. Only bit 0 of the control word (the mask) is stored, and its other bits read 0.
- R3: A table or pending-array access whose address bits 1:0 are not zero is ignored: a write changes nothing and a read returns 0.
- R4: A request to a vector that is in range, flagged used and not effectively masked, made while the output is free, gives `msg_valid` on the next cycle with that entry's address and data.
- R5: A request whose index is N or above, or whose vector's use flag is low, produces no message and sets no pending bit.
- R6: A vector is effectively masked when enable is low, mask-all is high or its own mask bit is 1. A request to such a vector sets its pending bit, which appears in pending-array word v/32 at bit v mod 32, and produces no message.
- R7: A table write that clears the mask bit of a pending vector raises `scan_busy` on the next cycle. That vector's message is then sent and its pending bit cleared.
- R8: When the function mask goes from set to clear, every pending vector that is not masked on its own is sent exactly once, and its pending bit is cleared.
- R9: Dropping a vector's use flag clears its pending bit on the next cycle. No message for it follows when masking is later lifted.
- R10: A request to an unmasked vector that arrives while the output is stalled becomes a pending bit. That vector's message is sent after the stall ends.
- R11: `cap_tbl_size` reports N−1. Pending-array bits for vectors at N and above, which fill out whole 64-vector groups, read 0.
- R12: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr | input | 1 | Table write strobe |
| tbl_addr | input | clog2(16N) | Table byte address |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Table read data for `tbl_addr` (combinational) |
| pba_addr | input | clog2(8·ceil(N/64)) | Pending-array byte address |
| pba_rdata | output | 32 | Pending-array read data (combinational) |
| fn_enable | input | 1 | Function enable bit |
| fn_mask_all | input | 1 | Function mask-all bit |
| cap_tbl_size | output | 11 | Table size field, N−1 |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | 11 | Requested vector index |
| vec_used | input | N | Per-vector use flags |
| msg_valid | output | 1 | Message write valid |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| scan_busy | output | 1 | Rescan in progress |

## Verification
The request path is driven through a table of cases. Each case combines one of the three mask sources with unused and out-of-range indices. For every case the bench checks both the output channel and the pending array, so that an actual send can be told apart from a parked request and from a dropped one. Directed sequences then lift masking in three different ways: by clearing a vector's own mask bit, by clearing the function mask, and by ending an output stall. These show whether each trigger starts a rescan and whether each pending vector is sent exactly once. Further checks cover a use flag dropped while a bit is pending, misaligned accesses, and a reset applied in mid-operation.

// File: rtl/msgvec_pkg.sv
package msgvec_pkg;
   localparam int MAX_VEC     = 2048;
   localparam int REQ_IDX_W   = 11;
   localparam int ENTRY_BYTES = 16;

   typedef enum logic [1:0] {
      W_ADDR_LO = 2'd0,
      W_ADDR_HI = 2'd1,
      W_DATA    = 2'd2,
      W_CTRL    = 2'd3
   } word_sel_e;

   typedef struct packed {
      logic [63:0] addr;
      logic [31:0] data;
      logic        mask;
   } vec_entry_t;
endpackage

// File: rtl/msgvec_table.sv
module msgvec_table
   import msgvec_pkg::*;
#(
   parameter int NUM_VEC = 8,
   parameter int TBL_AW  = $clog2(NUM_VEC * ENTRY_BYTES),
   parameter int VIDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [TBL_AW-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output vec_entry_t        ent [NUM_VEC],
   output logic              unmask_evt
);
   logic [11:0]       a_vec;
   logic [VIDX_W-1:0] a_idx;
   logic              a_ok;
   word_sel_e         a_sel;

   assign a_vec = 12'(addr >> 4);
   assign a_idx = a_vec[VIDX_W-1:0];
   assign a_ok  = (addr[1:0] == 2'b00) && (32'(a_vec) < NUM_VEC);
   assign a_sel = word_sel_e'(addr[3:2]);

   // one storage slot per vector
   for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
      vec_entry_t e_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            e_q.addr <= '0;
            e_q.data <= '0;
            e_q.mask <= 1'b1;
         end else if (wr && a_ok && (a_vec == 12'(v))) begin
            case (a_sel)
               W_ADDR_LO: e_q.addr[31:0]  <= wdata;
               W_ADDR_HI: e_q.addr[63:32] <= wdata;
               W_DATA:    e_q.data        <= wdata;
               default:   e_q.mask        <= wdata[0];
            endcase
         end
      end
      assign ent[v] = e_q;
   end

   // a control write that lifts a set mask bit
   assign unmask_evt = wr && a_ok && (a_sel == W_CTRL) && !wdata[0] && ent[a_idx].mask;

   always_comb begin
      rdata = '0;
      if (a_ok) begin
         case (a_sel)
            W_ADDR_LO: rdata = ent[a_idx].addr[31:0];
            W_ADDR_HI: rdata = ent[a_idx].addr[63:32];
            W_DATA:    rdata = ent[a_idx].data;
            default:   rdata = {31'b0, ent[a_idx].mask};
         endcase
      end
   end
endmodule

// File: rtl/msgvec_pend.sv
module msgvec_pend #(
   parameter int NUM_VEC   = 8,
   parameter int PBA_WORDS = 2,
   parameter int PBA_AW    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] set,
   input  logic [NUM_VEC-1:0] clr,
   input  logic [NUM_VEC-1:0] used,
   output logic [NUM_VEC-1:0] pend,
   input  logic [PBA_AW-1:0]  pba_addr,
   output logic [31:0]        pba_rdata
);
   localparam int PBA_BITS = PBA_WORDS * 32;
   localparam int WIDX_W   = (PBA_AW > 2) ? PBA_AW - 2 : 1;

   logic [NUM_VEC-1:0]  pend_q;
   logic [PBA_BITS-1:0] padded;
   logic [31:0]         words [PBA_WORDS];
   logic [WIDX_W-1:0]   widx;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= ((pend_q & ~clr) | set) & used;
   end
   assign pend = pend_q;

   assign padded = PBA_BITS'(pend_q);
   for (genvar w = 0; w < PBA_WORDS; w++) begin : g_word
      assign words[w] = padded[w*32 +: 32];
   end

   assign widx = WIDX_W'(pba_addr >> 2);

   always_comb begin
      pba_rdata = '0;
      if ((pba_addr[1:0] == 2'b00) && (32'(widx) < PBA_WORDS))
         pba_rdata = words[widx];
   end
endmodule

// File: rtl/msgvec_scan.sv
module msgvec_scan #(
   parameter int NUM_VEC = 8,
   parameter int VIDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trigger,
   input  logic [NUM_VEC-1:0] cand,
   input  logic               slot_avail,
   output logic               emit,
   output logic [VIDX_W-1:0]  ptr,
   output logic               busy
);
   localparam int LEFT_W = $clog2(NUM_VEC + 1);

   logic [LEFT_W-1:0] left_q;
   logic [VIDX_W-1:0] ptr_q;
   logic              hit, adv;

   assign busy = (left_q != '0);
   assign ptr  = ptr_q;
   assign hit  = busy && cand[ptr_q];
   assign emit = hit && slot_avail;
   assign adv  = busy && (!hit || emit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         ptr_q  <= '0;
      end else begin
         if (trigger)  left_q <= LEFT_W'(NUM_VEC);
         else if (adv) left_q <= left_q - 1'b1;
         if (adv) ptr_q <= (ptr_q == VIDX_W'(NUM_VEC - 1)) ? '0 : ptr_q + 1'b1;
      end
   end
endmodule

// File: rtl/msgvec_ctrl.sv
module msgvec_ctrl
   import msgvec_pkg::*;
#(
   parameter  int NUM_VEC   = 8,
   localparam int TBL_AW    = $clog2(NUM_VEC * ENTRY_BYTES),
   localparam int PBA_WORDS = 2 * ((NUM_VEC + 63) / 64),
   localparam int PBA_AW    = $clog2(PBA_WORDS * 4),
   localparam int VIDX_W    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tbl_wr,
   input  logic [TBL_AW-1:0]    tbl_addr,
   input  logic [31:0]          tbl_wdata,
   output logic [31:0]          tbl_rdata,
   input  logic [PBA_AW-1:0]    pba_addr,
   output logic [31:0]          pba_rdata,
   input  logic                 fn_enable,
   input  logic                 fn_mask_all,
   output logic [10:0]          cap_tbl_size,
   input  logic                 req_valid,
   input  logic [REQ_IDX_W-1:0] req_vec,
   input  logic [NUM_VEC-1:0]   vec_used,
   output logic                 msg_valid,
   input  logic                 msg_ready,
   output logic [63:0]          msg_addr,
   output logic [31:0]          msg_data,
   output logic                 scan_busy
);
   if (NUM_VEC < 1 || NUM_VEC > MAX_VEC) begin : g_bad_size
      $fatal(1, "msgvec_ctrl: NUM_VEC out of range");
   end

   vec_entry_t         ent [NUM_VEC];
   logic [NUM_VEC-1:0] eff_mask, pend, cand, pset, pclr;
   logic [NUM_VEC-1:0] r_onehot, s_onehot;
   logic [VIDX_W-1:0]  r_idx, scan_ptr;
   logic               fmask, fmask_q, fn_unmask, tbl_unmask;
   logic               req_ok, r_masked, slot_free, direct_take, stall_cap;
   logic               scan_emit, scan_trig;

   msgvec_table #(.NUM_VEC(NUM_VEC), .TBL_AW(TBL_AW), .VIDX_W(VIDX_W)) u_table (
      .clk(clk), .rst_n(rst_n), .wr(tbl_wr), .addr(tbl_addr), .wdata(tbl_wdata),
      .rdata(tbl_rdata), .ent(ent), .unmask_evt(tbl_unmask)
   );

   assign fmask = !fn_enable || fn_mask_all;
   for (genvar v = 0; v < NUM_VEC; v++) begin : g_emask
      assign eff_mask[v] = fmask | ent[v].mask;
   end

   assign r_idx       = req_vec[VIDX_W-1:0];
   assign req_ok      = req_valid && (32'(req_vec) < NUM_VEC) && vec_used[r_idx];
   assign r_masked    = eff_mask[r_idx];
   assign slot_free   = !msg_valid || msg_ready;
   assign direct_take = req_ok && !r_masked && slot_free;
   assign stall_cap   = req_ok && !r_masked && !slot_free;
   assign fn_unmask   = fmask_q && !fmask;
   assign scan_trig   = tbl_unmask || fn_unmask || stall_cap;

   assign r_onehot = NUM_VEC'(1) << r_idx;
   assign s_onehot = NUM_VEC'(1) << scan_ptr;
   assign pset     = (req_ok && !direct_take) ? r_onehot : '0;
   assign pclr     = (direct_take ? r_onehot : '0) | (scan_emit ? s_onehot : '0);
   assign cand     = pend & ~eff_mask & vec_used;

   msgvec_pend #(.NUM_VEC(NUM_VEC), .PBA_WORDS(PBA_WORDS), .PBA_AW(PBA_AW)) u_pend (
      .clk(clk), .rst_n(rst_n), .set(pset), .clr(pclr), .used(vec_used),
      .pend(pend), .pba_addr(pba_addr), .pba_rdata(pba_rdata)
   );

   msgvec_scan #(.NUM_VEC(NUM_VEC), .VIDX_W(VIDX_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .trigger(scan_trig), .cand(cand),
      .slot_avail(slot_free && !direct_take), .emit(scan_emit),
      .ptr(scan_ptr), .busy(scan_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmask_q   <= 1'b1;
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else begin
         fmask_q <= fmask;
         if (direct_take) begin
            msg_valid <= 1'b1;
            msg_addr  <= ent[r_idx].addr;
            msg_data  <= ent[r_idx].data;
         end else if (scan_emit) begin
            msg_valid <= 1'b1;
            msg_addr  <= ent[scan_ptr].addr;
            msg_data  <= ent[scan_ptr].data;
         end else if (msg_ready) begin
            msg_valid <= 1'b0;
         end
      end
   end

   assign cap_tbl_size = 11'(NUM_VEC - 1);
endmodule

// File: rtl/msgvec_ctrl_chk.sv
module msgvec_ctrl_chk #(
   parameter int NUM_VEC = 8,
   parameter int VIDX_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               fn_enable,
   input logic               fn_mask_all,
   input logic               req_valid,
   input logic [10:0]        req_vec,
   input logic [NUM_VEC-1:0] vec_used,
   input logic               msg_valid,
   input logic               msg_ready,
   input logic [63:0]        msg_addr,
   input logic [31:0]        msg_data,
   input logic               scan_busy,
   input logic [NUM_VEC-1:0] pend,
   input logic               scan_emit,
   input logic [VIDX_W-1:0]  scan_ptr
);
   p_hold_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

   p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!fn_enable || fn_mask_all) && !msg_valid |=> !msg_valid);

   p_drop_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (32'(req_vec) >= NUM_VEC) && !msg_valid && !scan_busy |=> !msg_valid);

   p_scan_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      scan_emit |=> !pend[$past(scan_ptr)]);

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_unused
      p_unused_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(vec_used[v]) |=> !pend[v]);
   end
endmodule

bind msgvec_ctrl msgvec_ctrl_chk #(.NUM_VEC(NUM_VEC), .VIDX_W(VIDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .fn_enable(fn_enable), .fn_mask_all(fn_mask_all),
   .req_valid(req_valid), .req_vec(req_vec), .vec_used(vec_used),
   .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
   .msg_data(msg_data), .scan_busy(scan_busy), .pend(pend),
   .scan_emit(scan_emit), .scan_ptr(scan_ptr)
);

// File: tb/tb_msgvec_ctrl.sv
module tb_msgvec_ctrl;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tbl_wr = 1'b0;
   logic [6:0]  tbl_addr = '0;
   logic [31:0] tbl_wdata = '0;
   logic [31:0] tbl_rdata;
   logic [2:0]  pba_addr = '0;
   logic [31:0] pba_rdata;
   logic        fn_enable = 1'b0;
   logic        fn_mask_all = 1'b0;
   logic [10:0] cap_tbl_size;
   logic        req_valid = 1'b0;
   logic [10:0] req_vec = '0;
   logic [N-1:0] vec_used = '1;
   logic        msg_valid;
   logic        msg_ready = 1'b1;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;
   logic        scan_busy;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   msgvec_ctrl #(.NUM_VEC(N)) dut (
      .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_addr(tbl_addr),
      .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata), .pba_addr(pba_addr),
      .pba_rdata(pba_rdata), .fn_enable(fn_enable), .fn_mask_all(fn_mask_all),
      .cap_tbl_size(cap_tbl_size), .req_valid(req_valid), .req_vec(req_vec),
      .vec_used(vec_used), .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_addr(msg_addr), .msg_data(msg_data), .scan_busy(scan_busy)
   );

   // request cases: index, used, enable, mask-all, own mask, expect message
   typedef struct packed {
      logic [10:0] vec;
      logic        used;
      logic        en;
      logic        mall;
      logic        vmask;
      logic        exp_msg;
   } row_t;

   localparam row_t ROWS [8] = '{
      '{11'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
      '{11'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
      '{11'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
      '{11'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
      '{11'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{11'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
      '{11'd9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      '{11'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}
   };

   function automatic logic [63:0] exp_addr(input int v);
      return {32'h0000_00A5 + 32'(v), 32'hFEE0_0000 | (32'(v) << 4)};
   endfunction

   function automatic logic [31:0] exp_data(input int v);
      return 32'h5A00_0000 | 32'(v);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic twrite(input int a, input logic [31:0] d);
      tbl_addr  = 7'(a);
      tbl_wdata = d;
      tbl_wr    = 1'b1;
      @(negedge clk);
      tbl_wr    = 1'b0;
   endtask

   task automatic tread(input int a, output logic [31:0] d);
      tbl_addr = 7'(a);
      #1;
      d = tbl_rdata;
   endtask

   task automatic pread(input int a, output logic [31:0] d);
      pba_addr = 3'(a);
      #1;
      d = pba_rdata;
   endtask

   task automatic pulse_req(input int v);
      req_vec   = 11'(v);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic collect(input int cyc, input logic [31:0] da, input logic [31:0] db,
                          output int na, output int nb, output int nt, output bit busy_seen);
      na = 0; nb = 0; nt = 0; busy_seen = 0;
      for (int i = 0; i < cyc; i++) begin
         if (scan_busy) busy_seen = 1;
         if (msg_valid && msg_ready) begin
            nt++;
            if (msg_data == da) na++;
            if (msg_data == db) nb++;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      logic [31:0] d;
      int na, nb, nt;
      bit bs;

      repeat (3) tick();
      rst_n = 1'b1;

      // R1: reset state
      tread(0*16 + 12, d);  chk(d == 32'd1, "R1 mask vec0 after reset", d, 1);
      tread(7*16 + 12, d);  chk(d == 32'd1, "R1 mask vec7 after reset", d, 1);
      tread(3*16 + 0, d);   chk(d == 32'd0, "R1 addr vec3 after reset", d, 0);
      tread(3*16 + 8, d);   chk(d == 32'd0, "R1 data vec3 after reset", d, 0);
      pread(0, d);          chk(d == 32'd0, "R1 pending after reset", d, 0);
      chk(!msg_valid && !scan_busy, "R1 outputs idle", {msg_valid, scan_busy}, 0);
      // R11: size field
      chk(cap_tbl_size == 11'(N - 1), "R11 table size field", cap_tbl_size, N - 1);

      // program the table
      for (int v = 0; v < N; v++) begin
         twrite(v*16 + 0, exp_addr(v)[31:0]);
         twrite(v*16 + 4, exp_addr(v)[63:32]);
         twrite(v*16 + 8, exp_data(v));
      end
      // R2: layout readback
      tread(5*16 + 0, d); chk(d == exp_addr(5)[31:0],  "R2 addr low vec5", d, exp_addr(5)[31:0]);
      tread(5*16 + 4, d); chk(d == exp_addr(5)[63:32], "R2 addr high vec5", d, exp_addr(5)[63:32]);
      tread(5*16 + 8, d); chk(d == exp_data(5),        "R2 data vec5", d, exp_data(5));
      twrite(5*16 + 12, 32'hFFFF_FFFF);
      tread(5*16 + 12, d); chk(d == 32'd1, "R2 ctrl keeps only bit 0", d, 1);
      // R3: misaligned accesses
      twrite(2*16 + 9, 32'hDEAD_BEEF);
      tread(2*16 + 8, d); chk(d == exp_data(2), "R3 misaligned write ignored", d, exp_data(2));
      tread(2*16 + 9, d); chk(d == 32'd0, "R3 misaligned read zero", d, 0);

      for (int v = 0; v < N; v++) twrite(v*16 + 12, 32'd0);
      vec_used = '1;
      fn_enable = 1'b1;
      repeat (N + 3) tick();

      // table-driven request cases: R4, R5, R6
      for (int r = 0; r < 8; r++) begin
         row_t rw;
         int v;
         bit exp_pend;
         string tag;
         rw = ROWS[r];
         v = int'(rw.vec);
         fn_enable   = rw.en;
         fn_mask_all = rw.mall;
         vec_used = (rw.used || v >= N) ? '1 : ~(N'(1) << v);
         if (v < N) twrite(v*16 + 12, {31'b0, rw.vmask});
         repeat (N + 3) tick();
         pulse_req(v);
         exp_pend = (v < N) && rw.used && !rw.exp_msg;
         tag = rw.exp_msg ? "R4 unmasked request" : (exp_pend ? "R6 masked request" : "R5 dropped request");
         chk(msg_valid == rw.exp_msg, tag, msg_valid, rw.exp_msg);
         if (rw.exp_msg)
            chk(msg_data == exp_data(v) && msg_addr == exp_addr(v), "R4 message content",
                {msg_addr[31:0], msg_data}, {exp_addr(v)[31:0], exp_data(v)});
         pread(0, d);
         chk(d == (exp_pend ? (32'd1 << v) : 32'd0), tag, d, exp_pend ? (32'd1 << v) : 32'd0);
         vec_used = '0;
         tick();
         vec_used = '1;
         if (v < N) twrite(v*16 + 12, 32'd0);
         fn_enable = 1'b1;
         fn_mask_all = 1'b0;
         repeat (N + 3) tick();
      end

      // R7: clearing a vector mask sends its pending message
      twrite(6*16 + 12, 32'd1);
      pulse_req(6);
      pread(0, d); chk(d == 32'h40, "R7 pending before unmask", d, 32'h40);
      twrite(6*16 + 12, 32'd0);
      chk(scan_busy, "R7 busy after unmask write", scan_busy, 1);
      collect(3*N, exp_data(6), 32'hFFFF_FFFF, na, nb, nt, bs);
      chk(na == 1 && nt == 1, "R7 one message for vec6", nt, 1);
      pread(0, d); chk(d == 32'd0, "R7 pending cleared", d, 0);

      // R8: function unmask drains pending vectors
      fn_mask_all = 1'b1;
      pulse_req(2);
      pulse_req(4);
      pread(0, d); chk(d == 32'h14, "R8 two pending under mask-all", d, 32'h14);
      fn_mask_all = 1'b0;
      collect(3*N, exp_data(2), exp_data(4), na, nb, nt, bs);
      chk(na == 1 && nb == 1 && nt == 2, "R8 each pending sent once", {na[7:0], nb[7:0], nt[7:0]}, 24'h010102);
      chk(bs, "R8 busy during rescan", bs, 1);
      pread(0, d); chk(d == 32'd0, "R8 pending cleared", d, 0);

      // R9: dropping use flag clears pending
      fn_mask_all = 1'b1;
      pulse_req(1);
      pread(0, d); chk(d == 32'h2, "R9 pending set", d, 32'h2);
      pread(1, d); chk(d == 32'd0, "R3 misaligned pending read zero", d, 0);
      vec_used[1] = 1'b0;
      tick();
      pread(0, d); chk(d == 32'd0, "R9 pending cleared by use drop", d, 0);
      vec_used = '1;
      fn_mask_all = 1'b0;
      collect(3*N, exp_data(1), 32'hFFFF_FFFF, na, nb, nt, bs);
      chk(nt == 0, "R9 no message after unmask", nt, 0);

      // R10 / R12: stall capture and hold
      msg_ready = 1'b0;
      pulse_req(2);
      chk(msg_valid && msg_data == exp_data(2), "R4 message under stall", msg_data, exp_data(2));
      pulse_req(3);
      pread(0, d); chk(d == 32'h8, "R10 stalled request parked", d, 32'h8);
      repeat (3) tick();
      chk(msg_valid && msg_data == exp_data(2) && msg_addr == exp_addr(2), "R12 held under stall",
          msg_data, exp_data(2));
      msg_ready = 1'b1;
      collect(3*N, exp_data(2), exp_data(3), na, nb, nt, bs);
      chk(na == 1 && nb == 1 && nt == 2, "R10 stalled then parked sent", {na[7:0], nb[7:0], nt[7:0]}, 24'h010102);
      pread(0, d); chk(d == 32'd0, "R10 pending cleared", d, 0);

      // R11: padding word of pending array
      pread(4, d); chk(d == 32'd0, "R11 padding word zero", d, 0);

      // R1: reset in mid-operation
      fn_mask_all = 1'b1;
      pulse_req(5);
      pread(0, d); chk(d == 32'h20, "R6 pending before reset", d, 32'h20);
      rst_n = 1'b0;
      repeat (2) tick();
      rst_n = 1'b1;
      pread(0, d);        chk(d == 32'd0, "R1 pending cleared by reset", d, 0);
      tread(5*16 + 12, d); chk(d == 32'd1, "R1 mask set by reset", d, 1);
      tread(5*16 + 8, d);  chk(d == 32'd0, "R1 data cleared by reset", d, 0);
      chk(!msg_valid && !scan_busy, "R1 idle after reset", {msg_valid, scan_busy}, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule